// File: doc/BRIEF.md
# Ternary Match Array

This block is a small associative store. Each entry holds a key pattern, a per-bit care mask and a valid bit. A lookup presents a key and gets back locations, not data. Every valid entry is compared with the key in the same cycle. The block returns three results:

- a vector with one bit for each entry that matched;
- a flag that says whether any entry matched;
- the lowest matching index.

A care bit of 0 makes that stored bit a wildcard. A stored pattern `1X1` therefore accepts both `101` and `111`.

Entries are loaded one at a time through a write port. A single-cycle clear input drops every entry at once. A binary-compare input treats every stored bit as significant during the lookup, which gives exact-match behaviour without rewriting the stored masks. Lookup results are registered and appear one cycle after the request.

Top module: `tcam_match_array`

## Requirements
- R1: A lookup asserted with `srch_valid` in cycle N produces `rsp_valid` = 1 in cycle N+1. Its results are computed from the entry contents as they stood during cycle N.
- R2: An entry matches when it is valid and every key bit whose care bit is 1 equals the stored bit. A care bit of 0 is a wildcard. With stored bits 1X1, keys 101 and 111 both match and 110 does not.
- R3: Bit i of `rsp_match_vec` is 1 exactly when entry i matched. All matching entries are reported together.
- R4: `rsp_hit` is 1 when at least one entry matched and 0 when none did.
- R5: `rsp_addr` is the lowest index of a matching entry. It is 0 when nothing matched.
- R6: While `binary_mode` is 1, every care bit is treated as 1 during the compare. The stored masks are left unchanged, so they take effect again once `binary_mode` returns to 0.
- R7: With `wr_en` = 1, the entry at `wr_addr` takes `wr_data`, `wr_care` and `wr_valid` at the clock edge. Writing `wr_valid` = 0 removes the entry from all later lookups.
- R8: A lookup in the same cycle as a write compares against the contents held before that write.
- R9: `clear_all` = 1 invalidates every entry at the clock edge. It overrides a write issued in the same cycle.
- R10: After reset, every entry is invalid, and `rsp_valid`, `rsp_hit`, `rsp_match_vec` and `rsp_addr` are all 0.
- R11: In a cycle following one with `srch_valid` = 0, `rsp_valid` is 0. `rsp_match_vec`, `rsp_hit` and `rsp_addr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_addr | input | ADDR_W | Entry index to load |
| wr_data | input | KEY_W | Stored pattern bits |
| wr_care | input | KEY_W | Per-bit care mask (1 = compare, 0 = wildcard) |
| wr_valid | input | 1 | Valid bit written with the entry |
| clear_all | input | 1 | Invalidate every entry |
| binary_mode | input | 1 | Treat all care bits as 1 during lookup |
| srch_valid | input | 1 | Lookup request |
| srch_key | input | KEY_W | Lookup key |
| rsp_valid | output | 1 | Lookup results are valid this cycle |
| rsp_match_vec | output | ENTRIES | One bit per matching entry |
| rsp_hit | output | 1 | At least one entry matched |
| rsp_addr | output | ADDR_W | Lowest matching index |

## Verification
Two functions can fall in the same cycle: a lookup, and a change to the stored contents made by a write or by the clear. Both are provoked on purpose.

- A directed step overwrites an entry that the concurrent lookup would match. The bench expects the old contents to be reported, and expects the new contents on the next lookup.
- Another step issues a clear together with a write, and a later lookup must find nothing.
- Random traffic mixes writes, clears, mode changes and lookups freely.

In every case the bench model computes its expectation from the contents before the edge and applies the updates only afterwards.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic {
    CMP_TERNARY = 1'b0,
    CMP_BINARY  = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/tcam_entry.sv
module tcam_entry
  import tcam_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [KEY_W-1:0] wr_data,
  input  logic [KEY_W-1:0] wr_care,
  input  logic             wr_valid,
  input  logic             clear_all,
  input  cmp_mode_e        cmp_mode,
  input  logic [KEY_W-1:0] key,
  output logic             match
);
  logic             valid_q, valid_d;
  logic [KEY_W-1:0] data_q, care_q;
  logic             load_en;
  logic [KEY_W-1:0] eff_care;

  // next state
  always_comb begin
    load_en = wr_sel && !clear_all;
    valid_d = valid_q;
    if (clear_all)   valid_d = 1'b0;
    else if (wr_sel) valid_d = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      data_q <= wr_data;
      care_q <= wr_care;
    end
  end

  // compare
  always_comb begin
    eff_care = (cmp_mode == CMP_BINARY) ? {KEY_W{1'b1}} : care_q;
    match    = valid_q && (((data_q ^ key) & eff_care) == '0);
  end

  // R9: clear leaves the entry invalid
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> !valid_q);
  // R7: an invalidating write removes the entry
  assert_write_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !wr_valid) |=> !match);
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int N  = 16,
  parameter int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [AW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
  end
endmodule

// File: rtl/tcam_match_array.sv
module tcam_match_array
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 8,
  localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [KEY_W-1:0]   wr_data,
  input  logic [KEY_W-1:0]   wr_care,
  input  logic               wr_valid,
  input  logic               clear_all,
  input  logic               binary_mode,
  input  logic               srch_valid,
  input  logic [KEY_W-1:0]   srch_key,
  output logic               rsp_valid,
  output logic [ENTRIES-1:0] rsp_match_vec,
  output logic               rsp_hit,
  output logic [ADDR_W-1:0]  rsp_addr
);
  cmp_mode_e          cmp_mode;
  logic [ENTRIES-1:0] match_w;
  logic               any_w;
  logic [ADDR_W-1:0]  idx_w;

  logic               vld_q, vld_d;
  logic [ENTRIES-1:0] vec_q, vec_d;
  logic               hit_q, hit_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;

  assign cmp_mode = binary_mode ? CMP_BINARY : CMP_TERNARY;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    tcam_entry #(.KEY_W(KEY_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_en && (wr_addr == ADDR_W'(g))),
      .wr_data   (wr_data),
      .wr_care   (wr_care),
      .wr_valid  (wr_valid),
      .clear_all (clear_all),
      .cmp_mode  (cmp_mode),
      .key       (srch_key),
      .match     (match_w[g])
    );
  end

  tcam_prio_enc #(.N(ENTRIES), .AW(ADDR_W)) u_prio (
    .req (match_w),
    .any (any_w),
    .idx (idx_w)
  );

  // next state
  always_comb begin
    vld_d  = srch_valid;
    vec_d  = vec_q;
    hit_d  = hit_q;
    addr_d = addr_q;
    if (srch_valid) begin
      vec_d  = match_w;
      hit_d  = any_w;
      addr_d = idx_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      vec_q  <= '0;
      hit_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      vec_q  <= vec_d;
      hit_q  <= hit_d;
      addr_q <= addr_d;
    end
  end

  assign rsp_valid     = vld_q;
  assign rsp_match_vec = vec_q;
  assign rsp_hit       = hit_q;
  assign rsp_addr      = addr_q;

  // R1: response follows a request by one cycle
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    srch_valid |=> rsp_valid);
  // R11: no request, no response, held results
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_valid |=> (!rsp_valid && $stable(rsp_match_vec) && $stable(rsp_addr)));
  // R4: hit flag agrees with the match vector
  assert_hit_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit == (rsp_match_vec != '0));
  // R5: reported index matched and nothing lower did
  assert_lowest_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_match_vec[rsp_addr] &&
      ((rsp_match_vec & ((ENTRIES'(1) << rsp_addr) - ENTRIES'(1))) == '0)));
  // R5: index is zero on a miss
  assert_miss_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_addr == '0));
endmodule

// File: tb/tcam_match_array_test.sv
module tcam_match_array_test;
  localparam int ENTRIES = 16;
  localparam int KEY_W   = 8;
  localparam int ADDR_W  = $clog2(ENTRIES);

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [KEY_W-1:0]   wr_data;
  logic [KEY_W-1:0]   wr_care;
  logic               wr_valid;
  logic               clear_all;
  logic               binary_mode;
  logic               srch_valid;
  logic [KEY_W-1:0]   srch_key;
  logic               rsp_valid;
  logic [ENTRIES-1:0] rsp_match_vec;
  logic               rsp_hit;
  logic [ADDR_W-1:0]  rsp_addr;

  tcam_match_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_care(wr_care), .wr_valid(wr_valid),
    .clear_all(clear_all), .binary_mode(binary_mode),
    .srch_valid(srch_valid), .srch_key(srch_key),
    .rsp_valid(rsp_valid), .rsp_match_vec(rsp_match_vec),
    .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_tests = 0;
  int n_fail  = 0;

  logic [KEY_W-1:0]   m_data [ENTRIES];
  logic [KEY_W-1:0]   m_care [ENTRIES];
  logic               m_val  [ENTRIES];
  logic [ENTRIES-1:0] last_vec  = '0;
  logic               last_hit  = 1'b0;
  logic [ADDR_W-1:0]  last_addr = '0;

  function automatic logic [ENTRIES-1:0] model_vec(logic [KEY_W-1:0] key, logic bm);
    logic [ENTRIES-1:0] v = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      logic [KEY_W-1:0] c = bm ? {KEY_W{1'b1}} : m_care[i];
      v[i] = m_val[i] && ((c & (key ^ m_data[i])) == '0);
    end
    return v;
  endfunction

  function automatic logic [ADDR_W-1:0] model_low(logic [ENTRIES-1:0] v);
    for (int i = 0; i < ENTRIES; i++) if (v[i]) return ADDR_W'(i);
    return '0;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drives one cycle from a negedge; checks at the following negedge.
  task automatic step(logic we, int wa, logic [KEY_W-1:0] wd, logic [KEY_W-1:0] wc,
                      logic wv, logic clr, logic bm, logic sv,
                      logic [KEY_W-1:0] key, string req);
    logic [ENTRIES-1:0] ev;
    wr_en = we; wr_addr = ADDR_W'(wa); wr_data = wd; wr_care = wc; wr_valid = wv;
    clear_all = clr; binary_mode = bm; srch_valid = sv; srch_key = key;
    ev = model_vec(key, bm);
    @(posedge clk);
    if (clr) begin
      for (int i = 0; i < ENTRIES; i++) m_val[i] = 1'b0;
    end else if (we) begin
      m_data[wa] = wd; m_care[wa] = wc; m_val[wa] = wv;
    end
    if (sv) begin
      last_vec = ev; last_hit = (ev != '0); last_addr = model_low(ev);
    end
    @(negedge clk);
    check(req, "rsp_valid", rsp_valid, sv);
    check(req, "match_vec", rsp_match_vec, last_vec);
    check(req, "hit", rsp_hit, last_hit);
    check(req, "addr", rsp_addr, last_addr);
  endtask

  task automatic srch(logic [KEY_W-1:0] key, logic bm, string req);
    step(1'b0, 0, '0, '0, 1'b0, 1'b0, bm, 1'b1, key, req);
  endtask

  task automatic wr(int a, logic [KEY_W-1:0] d, logic [KEY_W-1:0] c, logic v, string req);
    step(1'b1, a, d, c, v, 1'b0, 1'b0, 1'b0, '0, req);
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin m_val[i] = 0; m_data[i] = 0; m_care[i] = 0; end
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; wr_care = 0; wr_valid = 0;
    clear_all = 0; binary_mode = 0; srch_valid = 0; srch_key = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", "rsp_valid", rsp_valid, 0);
    check("R10", "hit", rsp_hit, 0);
    check("R10", "match_vec", rsp_match_vec, 0);
    check("R10", "addr", rsp_addr, 0);
    srch(8'h00, 1'b0, "R10");  // nothing valid after reset

    // R2: stored 1X1 in bits 2..0
    wr(3, 8'b0000_0101, 8'b1111_1101, 1'b1, "R7");
    srch(8'b0000_0101, 1'b0, "R2");
    srch(8'b0000_0111, 1'b0, "R2");
    srch(8'b0000_0110, 1'b0, "R2");
    // R6: binary mode forces the wildcard bit to count, then the mask returns
    srch(8'b0000_0111, 1'b1, "R6");
    srch(8'b0000_0101, 1'b1, "R6");
    srch(8'b0000_0111, 1'b0, "R6");

    // R3/R5: several entries hold the same key
    wr(9, 8'hA0, 8'hFF, 1'b1, "R7");
    wr(5, 8'hA0, 8'hFF, 1'b1, "R7");
    srch(8'hA0, 1'b0, "R3");
    // R8: write to entry 5 during a lookup sees old contents
    step(1'b1, 5, 8'h11, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA0, "R8");
    srch(8'hA0, 1'b0, "R5");
    // R11: idle cycles hold results
    step(1'b0, 0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA0, "R11");
    step(1'b0, 0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, "R11");
    // R7/R4: invalidating write gives a miss
    wr(9, 8'hA0, 8'hFF, 1'b0, "R7");
    srch(8'hA0, 1'b0, "R4");
    // R9: clear wins over a concurrent write; lookup beside clear sees old contents
    step(1'b1, 2, 8'h33, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11, "R9");
    srch(8'h33, 1'b0, "R9");
    srch(8'h11, 1'b0, "R9");
    // R5: highest entry only
    wr(15, 8'h00, 8'h00, 1'b1, "R7");
    srch(8'h5A, 1'b0, "R5");

    // random traffic, fixed seed
    void'($urandom(32'd2718));
    for (int n = 0; n < 3000; n++) begin
      logic we  = ($urandom_range(0, 99) < 30);
      logic clr = ($urandom_range(0, 99) < 2);
      logic bm  = ($urandom_range(0, 99) < 20);
      logic sv  = ($urandom_range(0, 99) < 70);
      logic [KEY_W-1:0] d = {4'h5, 4'($urandom_range(0, 15))};
      logic [KEY_W-1:0] c = KEY_W'($urandom) | 8'hF0;
      logic [KEY_W-1:0] k = {4'h5, 4'($urandom_range(0, 15))};
      step(we, int'($urandom_range(0, ENTRIES - 1)), d, c,
           ($urandom_range(0, 9) != 0), clr, bm, sv, k, "R3");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule